// File: doc/BRIEF.md
# Asynchronous Multiplexed Bus Target with Single-Strobe Conversion

This block lets a host processor reach on-chip registers over an asynchronous parallel bus whose 16 address/data lines are shared in time. The host first places an address on the shared lines and marks it with an address-valid strobe. It then either places write data and pulses write-enable, or pulses output-enable and expects read data back on the same lines. Chip-select frames the whole access. The host pins carry no clock. The block therefore latches the address and the write data directly on the host's own strobe edges into holding registers. It passes chip-select, write-enable and output-enable through two-flop synchronizers into the system clock domain.

Inside the system domain, write-enable and output-enable are each qualified by chip-select and edge-detected. A write is recognised when the qualified write-enable is released. A read is recognised when the qualified output-enable is asserted. Each recognised access copies the held address (and, for a write, the held data) onto an internal register-side bus and raises a strobe for exactly one system clock. For a read, the register side answers one clock after the read strobe. That answer is held and presented on the read-data pins, whose output enable is on only while chip-select and output-enable are both low. The host timing keeps every control phase at least 30 ns long, so the edges are seen reliably at a 100 MHz system clock.

Top module: `amb_target`

## Requirements
- R1: After reset, `sb_wr` and `sb_rd` are 0, `sb_addr` and `sb_wr_data` are 0, and `ad_out_en` is 0 while `bus_cs_n` and `bus_oe_n` are high.
- R2: The value on `ad_in` at the rising edge of `bus_adv_n` is the value presented on `sb_addr` with the strobe of the following access.
- R3: The value on `ad_in` at the falling edge of `bus_we_n` is the value presented on `sb_wr_data`; a later change of `ad_in` while `bus_we_n` stays low does not alter it.
- R4: One host write (chip-select low, write-enable pulsed low once) yields exactly one `sb_wr` pulse, which lasts one system clock.
- R5: No `sb_wr` occurs while `bus_we_n` is still held low; the write strobe follows the release of write-enable.
- R6: One host read (chip-select low, output-enable pulsed low once) yields exactly one `sb_rd` pulse of one system clock, carrying the latched address on `sb_addr`.
- R7: The value on `sb_rd_data` in the clock after `sb_rd` is driven on `ad_out` while the host keeps chip-select and output-enable low.
- R8: `ad_out_en` is 1 only while both `bus_cs_n` and `bus_oe_n` are low, and is 0 as soon as either is high.
- R9: Write-enable and output-enable pulses with `bus_cs_n` high produce neither `sb_wr` nor `sb_rd`.
- R10: When the release of write-enable and the assertion of output-enable occur together within one chip-select, both strobes fire once each and in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| bus_adv_n | input | 1 | Host address-valid strobe, active low; address taken on its rising edge |
| bus_we_n | input | 1 | Host write-enable, active low; data taken on its falling edge |
| bus_oe_n | input | 1 | Host output-enable, active low |
| ad_in | input | 16 | Multiplexed address/data from the host |
| ad_out | output | 16 | Read data towards the host |
| ad_out_en | output | 1 | Output enable for the address/data pads |
| sb_addr | output | 16 | Register-side address, updated with each strobe |
| sb_wr | output | 1 | Register-side write strobe, one clock per host write |
| sb_wr_data | output | 16 | Register-side write data |
| sb_rd | output | 1 | Register-side read strobe, one clock per host read |
| sb_rd_data | input | 16 | Register-side read data, valid the clock after `sb_rd` |

## Verification
The write-completion detector and the read-start detector are separate paths, and both can fire on the same system clock. The bench provokes this by releasing write-enable and asserting output-enable at the same instant within one chip-select. It then judges the result by counting each strobe exactly once and by confirming that a clock existed with both strobes high. It also checks that the write still carries its latched data and that the read returns the answer for the shared address.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam int unsigned AMB_AD_W  = 16;
  localparam int unsigned AMB_SYNC  = 2;

  // Active-low control qualified by active-low chip-select.
  function automatic logic ctl_active(input logic cs_n, input logic ctl_n);
    return !cs_n && !ctl_n;
  endfunction

  // Trailing edge of a qualified level (previous high, now low).
  function automatic logic trail_edge(input logic prev, input logic now);
    return prev && !now;
  endfunction

  // Leading edge of a qualified level (previous low, now high).
  function automatic logic lead_edge(input logic prev, input logic now);
    return !prev && now;
  endfunction
endpackage

// File: rtl/amb_sync.sv
module amb_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/amb_capture.sv
module amb_capture #(
  parameter int unsigned AD_W = 16
) (
  input  logic            rst_n,
  input  logic            bus_adv_n,
  input  logic            bus_we_n,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] addr_hold,
  output logic [AD_W-1:0] data_hold
);
  // Address taken when the host ends the address phase.
  always_ff @(posedge bus_adv_n or negedge rst_n) begin
    if (!rst_n) addr_hold <= '0;
    else        addr_hold <= ad_in;
  end

  // Write data taken when the host starts the write pulse.
  always_ff @(negedge bus_we_n or negedge rst_n) begin
    if (!rst_n) data_hold <= '0;
    else        data_hold <= ad_in;
  end
endmodule

// File: rtl/amb_strobe_gen.sv
module amb_strobe_gen #(
  parameter int unsigned AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_s,
  input  logic            we_s,
  input  logic            oe_s,
  input  logic [AD_W-1:0] addr_hold,
  input  logic [AD_W-1:0] data_hold,
  output logic [AD_W-1:0] sb_addr,
  output logic            sb_wr,
  output logic [AD_W-1:0] sb_wr_data,
  output logic            sb_rd
);
  import amb_pkg::*;

  logic wr_act, rd_act, wr_act_q, rd_act_q;
  logic wr_evt, rd_evt;

  assign wr_act = ctl_active(cs_s, we_s);
  assign rd_act = ctl_active(cs_s, oe_s);
  assign wr_evt = trail_edge(wr_act_q, wr_act);
  assign rd_evt = lead_edge(rd_act_q, rd_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q   <= 1'b0;
      rd_act_q   <= 1'b0;
      sb_wr      <= 1'b0;
      sb_rd      <= 1'b0;
      sb_addr    <= '0;
      sb_wr_data <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      sb_wr    <= wr_evt;
      sb_rd    <= rd_evt;
      if (wr_evt || rd_evt) sb_addr <= addr_hold;
      if (wr_evt)           sb_wr_data <= data_hold;
    end
  end

  // R4: a write strobe never lasts beyond one clock
  a_r4_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wr |=> !sb_wr);

  // R6: a read strobe never lasts beyond one clock
  a_r6_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sb_rd |=> !sb_rd);

  // R5: a write strobe only follows a synchronized release of write-enable
  a_r5_wr_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wr |-> $past(cs_s || we_s));

  // R9: a write strobe needs chip-select and write-enable active before
  a_r9_wr_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wr |-> $past(!cs_s && !we_s, 2));

  // R9: a read strobe needs chip-select and output-enable active
  a_r9_rd_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sb_rd |-> $past(!cs_s && !oe_s));
endmodule

// File: rtl/amb_rd_return.sv
module amb_rd_return #(
  parameter int unsigned AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs_n,
  input  logic            bus_oe_n,
  input  logic            sb_rd,
  input  logic [AD_W-1:0] sb_rd_data,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_out_en
);
  import amb_pkg::*;

  logic            rd_fetch;
  logic [AD_W-1:0] rd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_fetch <= 1'b0;
      rd_hold  <= '0;
    end else begin
      rd_fetch <= sb_rd;
      if (rd_fetch) rd_hold <= sb_rd_data;
    end
  end

  assign ad_out    = rd_hold;
  assign ad_out_en = ctl_active(bus_cs_n, bus_oe_n);

  // R7: the held answer only changes in the clock after a read strobe
  a_r7_hold_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sb_rd) |=> $stable(rd_hold));
endmodule

// File: rtl/amb_target.sv
module amb_target #(
  parameter int unsigned AD_W   = amb_pkg::AMB_AD_W,
  parameter int unsigned STAGES = amb_pkg::AMB_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs_n,
  input  logic            bus_adv_n,
  input  logic            bus_we_n,
  input  logic            bus_oe_n,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_out_en,
  output logic [AD_W-1:0] sb_addr,
  output logic            sb_wr,
  output logic [AD_W-1:0] sb_wr_data,
  output logic            sb_rd,
  input  logic [AD_W-1:0] sb_rd_data
);
  localparam int unsigned N_CTL = 3;

  logic [AD_W-1:0]  addr_hold, data_hold;
  logic [N_CTL-1:0] ctl_raw, ctl_s;
  logic             cs_s, we_s, oe_s;

  assign ctl_raw = {bus_oe_n, bus_we_n, bus_cs_n};
  assign cs_s    = ctl_s[0];
  assign we_s    = ctl_s[1];
  assign oe_s    = ctl_s[2];

  amb_capture #(.AD_W(AD_W)) u_cap (
    .rst_n     (rst_n),
    .bus_adv_n (bus_adv_n),
    .bus_we_n  (bus_we_n),
    .ad_in     (ad_in),
    .addr_hold (addr_hold),
    .data_hold (data_hold)
  );

  amb_sync #(.W(N_CTL), .STAGES(STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  amb_strobe_gen #(.AD_W(AD_W)) u_strb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .we_s       (we_s),
    .oe_s       (oe_s),
    .addr_hold  (addr_hold),
    .data_hold  (data_hold),
    .sb_addr    (sb_addr),
    .sb_wr      (sb_wr),
    .sb_wr_data (sb_wr_data),
    .sb_rd      (sb_rd)
  );

  amb_rd_return #(.AD_W(AD_W)) u_rret (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_oe_n   (bus_oe_n),
    .sb_rd      (sb_rd),
    .sb_rd_data (sb_rd_data),
    .ad_out     (ad_out),
    .ad_out_en  (ad_out_en)
  );

  // R10: both strobes of one cycle carry the same address (no split update)
  a_r10_shared_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_wr && sb_rd) |-> (sb_addr == addr_hold));
endmodule

// File: tb/tb_amb_target.sv
module tb_amb_target;
  localparam int AD_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_cs_n = 1'b1, bus_adv_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [AD_W-1:0] ad_in = '0;
  logic [AD_W-1:0] ad_out, sb_addr, sb_wr_data;
  logic [AD_W-1:0] sb_rd_data = '0;
  logic            ad_out_en, sb_wr, sb_rd;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
  logic [AD_W-1:0] wr_addr_seen = '0, wr_data_seen = '0, rd_addr_seen = '0;
  bit done = 0;

  always #10 clk = ~clk;

  amb_target dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
    .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .ad_in(ad_in),
    .ad_out(ad_out), .ad_out_en(ad_out_en), .sb_addr(sb_addr),
    .sb_wr(sb_wr), .sb_wr_data(sb_wr_data), .sb_rd(sb_rd),
    .sb_rd_data(sb_rd_data)
  );

  function automatic logic [AD_W-1:0] reg_answer(input logic [AD_W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  // Register-side model: answers one clock after the read strobe.
  always @(posedge clk) if (sb_rd) sb_rd_data <= reg_answer(sb_addr);

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (sb_wr) begin wr_cnt++; wr_addr_seen = sb_addr; wr_data_seen = sb_wr_data; end
    if (sb_rd) begin rd_cnt++; rd_addr_seen = sb_addr; end
    if (sb_wr && sb_rd) both_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    wr_cnt = 0; rd_cnt = 0; both_cnt = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [AD_W-1:0] a);
    bus_cs_n = 1'b0; ad_in = a; bus_adv_n = 1'b0;
    wait_clk(2);
    bus_adv_n = 1'b1;
    wait_clk(1);
    ad_in = 16'hDEAD;
  endtask

  task automatic t_reset();
    chk("R1 sb_wr", sb_wr, 0);
    chk("R1 sb_rd", sb_rd, 0);
    chk("R1 sb_addr", sb_addr, 0);
    chk("R1 sb_wr_data", sb_wr_data, 0);
    chk("R1 ad_out_en", ad_out_en, 0);
  endtask

  task automatic t_write(input logic [AD_W-1:0] a, input logic [AD_W-1:0] d);
    clr();
    addr_phase(a);
    ad_in = d; wait_clk(1);
    bus_we_n = 1'b0; wait_clk(1);
    ad_in = ~d;                          // R3: late change must be ignored
    wait_clk(6);
    chk("R5 no strobe while we low", wr_cnt, 0);
    bus_we_n = 1'b1; wait_clk(2);
    bus_cs_n = 1'b1; wait_clk(8);
    chk("R4 one write strobe", wr_cnt, 1);
    chk("R2 write address", wr_addr_seen, a);
    chk("R3 write data", wr_data_seen, d);
    chk("R4 no read strobe", rd_cnt, 0);
  endtask

  task automatic t_read(input logic [AD_W-1:0] a);
    clr();
    addr_phase(a);
    chk("R8 released before oe", ad_out_en, 0);
    bus_oe_n = 1'b0; #1;
    chk("R8 enabled with cs and oe low", ad_out_en, 1);
    wait_clk(10);
    chk("R7 read data on pads", ad_out, reg_answer(a));
    bus_oe_n = 1'b1; #1;
    chk("R8 released after oe high", ad_out_en, 0);
    wait_clk(2);
    bus_cs_n = 1'b1; wait_clk(8);
    chk("R6 one read strobe", rd_cnt, 1);
    chk("R6 read address", rd_addr_seen, a);
    chk("R6 no write strobe", wr_cnt, 0);
  endtask

  task automatic t_no_cs();
    clr();
    bus_cs_n = 1'b1;
    bus_adv_n = 1'b0; ad_in = 16'h0F0F; wait_clk(2); bus_adv_n = 1'b1;
    bus_we_n = 1'b0; wait_clk(4); bus_we_n = 1'b1; wait_clk(3);
    bus_oe_n = 1'b0; #1;
    chk("R8 no enable with cs high", ad_out_en, 0);
    wait_clk(6); bus_oe_n = 1'b1; wait_clk(6);
    chk("R9 no write strobe without cs", wr_cnt, 0);
    chk("R9 no read strobe without cs", rd_cnt, 0);
  endtask

  task automatic t_same_cycle(input logic [AD_W-1:0] a, input logic [AD_W-1:0] d);
    clr();
    addr_phase(a);
    ad_in = d; wait_clk(1);
    bus_we_n = 1'b0; wait_clk(4);
    bus_we_n = 1'b1; bus_oe_n = 1'b0;
    wait_clk(10);
    chk("R10 read data after joint edge", ad_out, reg_answer(a));
    bus_oe_n = 1'b1; wait_clk(2);
    bus_cs_n = 1'b1; wait_clk(8);
    chk("R10 write strobe once", wr_cnt, 1);
    chk("R10 read strobe once", rd_cnt, 1);
    chk("R10 strobes in same clock", both_cnt, 1);
    chk("R10 write data kept", wr_data_seen, d);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_write(16'h0012, 16'h0ABC);
    t_write(16'hFFFF, 16'h0000);
    t_read(16'h0009);
    t_read(16'h8001);
    t_no_cs();
    t_same_cycle(16'h0014, 16'h0001);
    // R4 back-to-back writes each counted separately
    t_write(16'h0013, 16'h0F00);
    t_write(16'h0013, 16'h00F0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule